// File: doc/BRIEF.md
# Protection Region Address Matcher

This block decides whether a 32-bit bus transfer address lies inside one configurable protection region, and whether the part of the region it lands in is enabled. Software loads a 32-bit region word through a simple write port. The word holds a base address in its upper 24 bits and an 8-bit subregion-off mask in its lower 8 bits. A 5-bit size code, supplied alongside from the region's attribute logic, sets the region size to a power of two.

A region is always aligned to its own size, so base bits below the size boundary take no part in the compare. The region is cut into eight equal subregions, and any of them can be removed from the match. The block reports three things: whether the address lies inside the region, which subregion it addresses, and a hit flag. The hit flag tells downstream permission logic that this region's attributes apply to the transfer.

The match path is purely combinational from the address, the size code, the enable input and the stored word. Only the region word is registered.

Top module: `mpu_region_match`

## Requirements
- R1: After reset the region word reads 0 on `cfg_word`.
- R2: A clock edge with `wr_en` high loads `wr_data` into the region word. An edge with `wr_en` low leaves the word unchanged, whatever `wr_data` holds.
- R3: With effective size code e, the region spans 2^(e+1) bytes starting at the base `{cfg_word[31:8], 8'h00}` rounded down to a multiple of 2^(e+1). `in_region` is 1 exactly when the address lies in that span. Base bits below bit e+1 are ignored.
- R4: Size codes 0 to 6 behave exactly as code 7, a 256-byte region made of 32-byte subregions.
- R5: Size code 31 covers the whole 4 GByte space, so `in_region` is 1 for every address.
- R6: `sub_idx` equals address bits [e : e-2], the number of the eighth of the region being addressed.
- R7: Bit k of the region word (k = 0..7) removes subregion k. When that bit is set, `hit` is 0 for addresses in subregion k.
- R8: `hit` is 1 exactly when `region_en` is 1, `in_region` is 1, and the mask bit selected by `sub_idx` is 0.
- R9: When `region_en` is 0, `hit` is 0 for every address and configuration.
- R10: `hit`, `in_region` and `sub_idx` follow a change of `addr` or `size_code` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the region word register |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load strobe for the region word |
| wr_data | input | 32 | New region word: base in [31:8], subregion-off mask in [7:0] |
| region_en | input | 1 | Region enable; low forces `hit` to 0 |
| size_code | input | 5 | Region size code; region holds 2^(max(code,7)+1) bytes |
| addr | input | 32 | Bus transfer address under test |
| hit | output | 1 | Address is in an enabled subregion of an enabled region |
| in_region | output | 1 | Address lies inside the aligned region span |
| sub_idx | output | 3 | Subregion number addressed inside the region |
| cfg_word | output | 32 | Current region word |

## Verification
The assertions take `size_code` and `addr` to be settled between clock edges, because the checker samples the combinational outputs at the edge. They also take reset to be applied with `wr_en` low, so that the first cycle after reset sees the cleared word. The bench changes `addr`, `size_code` and `region_en` only in the low clock phase, and holds `wr_en` low while reset is asserted. It aims half of its random addresses inside the current aligned span so that hits, misses and masked subregions all occur often.

// File: rtl/mpu_rgn_pkg.sv
package mpu_rgn_pkg;
  localparam int ADDR_W   = 32;
  localparam int SIZE_W   = 5;
  localparam int SUB_N    = 8;
  localparam int SUB_W    = $clog2(SUB_N);
  localparam int MASK_W   = SUB_N;
  localparam int BASE_W   = ADDR_W - MASK_W;
  localparam int MIN_CODE = MASK_W - 1;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [MASK_W-1:0] sub_off;
  } rgn_word_t;

  // Effective size code: never below the smallest legal region.
  function automatic logic [SIZE_W-1:0] clamp_code(input logic [SIZE_W-1:0] c);
    return (c < SIZE_W'(MIN_CODE)) ? SIZE_W'(MIN_CODE) : c;
  endfunction

  // Subregion number: the SUB_W address bits just below the size boundary.
  function automatic logic [SUB_W-1:0] pick_sub(input logic [ADDR_W-1:0] a,
                                                input logic [SIZE_W-1:0] eff);
    logic [SUB_W-1:0] r;
    for (int k = 0; k < SUB_W; k++) begin
      r[k] = a[int'(eff) - (SUB_W - 1) + k];
    end
    return r;
  endfunction
endpackage

// File: rtl/mpu_rgn_cfg_reg.sv
module mpu_rgn_cfg_reg
  import mpu_rgn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output rgn_word_t         cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= rgn_word_t'(wr_data);
    end
  end
endmodule

// File: rtl/mpu_rgn_size_dec.sv
module mpu_rgn_size_dec
  import mpu_rgn_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code,
  output logic [SIZE_W-1:0] eff_code,
  output logic [ADDR_W-1:0] keep_mask
);
  assign eff_code = clamp_code(size_code);

  // Keep (compare) only address bits strictly above the effective code.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    assign keep_mask[i] = (eff_code < SIZE_W'(i));
  end
endmodule

// File: rtl/mpu_rgn_addr_cmp.sv
module mpu_rgn_addr_cmp
  import mpu_rgn_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base_full,
  input  logic [ADDR_W-1:0] keep_mask,
  input  logic [SIZE_W-1:0] eff_code,
  input  logic [MASK_W-1:0] sub_mask,
  output logic              in_region,
  output logic [SUB_W-1:0]  sub_idx,
  output logic              sub_off
);
  logic [ADDR_W-1:0] diff;

  assign diff      = (addr ^ base_full) & keep_mask;
  assign in_region = (diff == '0);
  assign sub_idx   = pick_sub(addr, eff_code);
  assign sub_off   = sub_mask[sub_idx];
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_rgn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              region_en,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              in_region,
  output logic [SUB_W-1:0]  sub_idx,
  output logic [ADDR_W-1:0] cfg_word
);
  rgn_word_t         cfg_q;
  logic [SIZE_W-1:0] eff_code;
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] base_full;
  logic              sub_off;

  mpu_rgn_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_q   (cfg_q)
  );

  mpu_rgn_size_dec u_size (
    .size_code (size_code),
    .eff_code  (eff_code),
    .keep_mask (keep_mask)
  );

  assign base_full = {cfg_q.base, {MASK_W{1'b0}}};

  mpu_rgn_addr_cmp u_cmp (
    .addr      (addr),
    .base_full (base_full),
    .keep_mask (keep_mask),
    .eff_code  (eff_code),
    .sub_mask  (cfg_q.sub_off),
    .in_region (in_region),
    .sub_idx   (sub_idx),
    .sub_off   (sub_off)
  );

  assign hit      = region_en & in_region & ~sub_off;
  assign cfg_word = cfg_q;
endmodule

// File: rtl/mpu_rgn_chk.sv
module mpu_rgn_chk
  import mpu_rgn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_data,
  input logic              region_en,
  input logic [SIZE_W-1:0] size_code,
  input logic              hit,
  input logic              in_region,
  input logic [SUB_W-1:0]  sub_idx,
  input logic [ADDR_W-1:0] cfg_word,
  input logic              sub_off
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_word == '0);

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_word == $past(wr_data));

  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_word));

  // R5
  full_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == '1) |-> in_region);

  // R7
  masked_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !cfg_word[sub_idx]);

  // R8
  hit_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (in_region && !sub_off));

  // R8
  open_gives_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_en && in_region && !sub_off) |-> hit);

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !region_en |-> !hit);
endmodule

bind mpu_region_match mpu_rgn_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .region_en (region_en),
  .size_code (size_code),
  .hit       (hit),
  .in_region (in_region),
  .sub_idx   (sub_idx),
  .cfg_word  (cfg_word),
  .sub_off   (sub_off)
);

// File: tb/sim_mpu_region_match.sv
module sim_mpu_region_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        region_en = 1'b0;
  logic [4:0]  size_code = '0;
  logic [31:0] addr = '0;
  logic        hit, in_region;
  logic [2:0]  sub_idx;
  logic [31:0] cfg_word;

  int errors = 0;
  int checks = 0;
  logic [31:0] shadow = '0;

  always #10 clk = ~clk;

  mpu_region_match u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .region_en(region_en), .size_code(size_code), .addr(addr),
    .hit(hit), .in_region(in_region), .sub_idx(sub_idx), .cfg_word(cfg_word)
  );

  function automatic int eff_of(input logic [4:0] c);
    return (int'(c) < 7) ? 7 : int'(c);
  endfunction

  function automatic logic [63:0] span_of(input logic [4:0] c);
    return 64'd1 << (eff_of(c) + 1);
  endfunction

  function automatic logic [63:0] start_of(input logic [31:0] w, input logic [4:0] c);
    logic [63:0] b;
    b = {32'd0, w[31:8], 8'd0};
    return b - (b % span_of(c));
  endfunction

  function automatic logic exp_in(input logic [31:0] w, input logic [4:0] c,
                                  input logic [31:0] a);
    logic [63:0] s, a64;
    s   = start_of(w, c);
    a64 = {32'd0, a};
    return (a64 >= s) && (a64 < s + span_of(c));
  endfunction

  function automatic logic [2:0] exp_idx(input logic [4:0] c, input logic [31:0] a);
    logic [63:0] part, q;
    part = span_of(c) / 8;
    q    = ({32'd0, a} % span_of(c)) / part;
    return q[2:0];
  endfunction

  function automatic logic exp_hit(input logic [31:0] w, input logic [4:0] c,
                                   input logic [31:0] a, input logic en);
    logic [2:0] k;
    k = exp_idx(c, a);
    return en && exp_in(w, c, a) && !w[k];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    shadow  = w;
  endtask

  task automatic probe(input logic [4:0] c, input logic [31:0] a, input logic en);
    size_code = c;
    addr      = a;
    region_en = en;
    #2;
  endtask

  task automatic check_all(input string req);
    check({req, " in_region"}, {31'd0, in_region}, {31'd0, exp_in(shadow, size_code, addr)});
    check({req, " sub_idx"}, {29'd0, sub_idx}, {29'd0, exp_idx(size_code, addr)});
    check({req, " hit"}, {31'd0, hit}, {31'd0, exp_hit(shadow, size_code, addr, region_en)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", cfg_word, 32'd0);

    // 64 KByte region, low base byte must be ignored (R3)
    write_word(32'h1234_5600);
    check("R2 load", cfg_word, 32'h1234_5600);
    probe(5'd15, 32'h1234_0000, 1'b1);
    check("R3 low base bits ignored", {31'd0, in_region}, 32'd1);
    check_all("R3 start");
    probe(5'd15, 32'h1234_E000, 1'b1);
    check("R6 top eighth idx", {29'd0, sub_idx}, 32'd7);
    probe(5'd15, 32'h1235_0000, 1'b1);
    check("R3 above span", {31'd0, in_region}, 32'd0);
    probe(5'd15, 32'h1233_FFFF, 1'b1);
    check("R3 below span", {31'd0, in_region}, 32'd0);

    // Hold: wr_en low ignores wr_data (R2)
    @(negedge clk);
    wr_data = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    check("R2 hold", cfg_word, 32'h1234_5600);

    // Subregion 7 removed (R7)
    write_word(32'h1234_5680);
    probe(5'd15, 32'h1234_E010, 1'b1);
    check("R7 masked in", {31'd0, in_region}, 32'd1);
    check("R7 masked hit", {31'd0, hit}, 32'd0);
    probe(5'd15, 32'h1234_C000, 1'b1);
    check("R7 open neighbour hit", {31'd0, hit}, 32'd1);

    // Clamp: code 0 acts as 256 bytes (R4)
    write_word(32'hABCD_EF00);
    probe(5'd0, 32'hABCD_EFFF, 1'b1);
    check("R4 clamp in", {31'd0, in_region}, 32'd1);
    check("R4 clamp idx", {29'd0, sub_idx}, 32'd7);
    probe(5'd3, 32'hABCD_F000, 1'b1);
    check("R4 clamp out", {31'd0, in_region}, 32'd0);
    probe(5'd6, 32'hABCD_EF20, 1'b1);
    check("R4 clamp sub1", {29'd0, sub_idx}, 32'd1);

    // Whole space (R5)
    probe(5'd31, 32'h0000_0000, 1'b1);
    check("R5 low end", {31'd0, in_region}, 32'd1);
    probe(5'd31, 32'hFFFF_FFFF, 1'b1);
    check("R5 high end", {31'd0, in_region}, 32'd1);
    check("R5 idx", {29'd0, sub_idx}, 32'd7);

    // Enable low (R9)
    probe(5'd31, 32'h4000_0000, 1'b0);
    check("R9 disabled", {31'd0, hit}, 32'd0);

    // Same-cycle response with no clock edge (R10)
    @(negedge clk);
    probe(5'd7, 32'hABCD_EF40, 1'b1);
    check("R10 idx a", {29'd0, sub_idx}, 32'd2);
    addr = 32'hABCD_EF60;
    #1;
    check("R10 idx b", {29'd0, sub_idx}, 32'd3);

    // Random mix (R8, R3, R6)
    for (int n = 0; n < 600; n++) begin
      logic [4:0] c;
      logic [31:0] a;
      if (($urandom % 4) == 0) write_word($urandom);
      @(negedge clk);
      c = 5'($urandom % 32);
      if (($urandom % 2) == 0) begin
        a = $urandom;
      end else begin
        a = 32'(start_of(shadow, c) + ({32'd0, $urandom} % span_of(c)));
      end
      probe(c, a, ($urandom % 8) != 0);
      check_all("R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule